// File: doc/BRIEF.md
# I2C Command Sequencer

This block is the byte-level control layer of an I2C master. Software fills a command queue with 10-bit entries. Each entry carries one data byte and two flags: one flag asks for a start condition before the byte, and the other asks for a stop condition after the operation. The sequencer takes entries off the queue one at a time. It turns each entry into operations for a lower bit-level engine: start, stop, write byte, or read byte with a chosen acknowledge. The engine takes care of SCL/SDA timing.

A start-flagged entry is an address phase: a start (or a repeated start while the bus is held) followed by the address byte. If that address byte has its direction bit set for a read, the next entry is a byte count, not data. The sequencer then reads that many bytes into a receive queue. It ACKs every byte except the last one, which it NACKs. Single-cycle events report a refused byte, the return of the bus to idle, and the command queue draining to empty or to half.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: After reset, eng_req, bus_busy, rx_valid and all four event outputs are 0, tx_empty is 1 and tx_level is 0.
- R2: Engine op codes are 0 start, 1 stop, 2 write byte, 3 read byte. A command entry uses bits 7:0 for data, bit 8 for the start flag and bit 9 for the stop flag. A start-flagged entry produces a start and then a write of its byte. An unflagged entry after a write address produces a write of its byte. A write entry with bit 9 set is followed by a stop once the byte is acknowledged.
- R3: After a start-flagged entry whose bit 0 is 1, the next entry gives a read count N (1 to 255) in bits 7:0. The block issues N reads with eng_nack_out 0 on all of them except the last, which has eng_nack_out 1. Received bytes enter the receive queue in order. If that entry's stop flag is set, a stop follows the last read.
- R4: An entry with both start and stop flags produces start, write of the address, stop.
- R5: A start-flagged entry while the bus is held issues a start with no stop before it, and bus_busy stays 1.
- R6: A NACK on any written byte pulses ev_tx_error, is followed by a stop, and discards every remaining command entry.
- R7: tx_level reads the entry count minus one (0 when empty). With 16 entries cmd_full is 1, and a further push is ignored.
- R8: ev_tx_empty pulses once when a pop leaves the queue empty. ev_tx_half pulses once when a pop brings the count down to half the depth.
- R9: While enable is 0, no entry is popped and no new operation is requested.
- R10: A tx_flush pulse empties the command queue and clears a pending read count.
- R11: bus_busy is 1 from the issued start until the stop completes, and ev_bus_idle pulses when the stop completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows entries to be taken from the command queue |
| tx_flush | input | 1 | Empties the command queue |
| cmd_push | input | 1 | Write cmd_data into the command queue |
| cmd_data | input | 10 | Command entry {stop, start, byte} |
| cmd_full | output | 1 | Command queue full |
| tx_empty | output | 1 | Command queue empty |
| tx_level | output | 4 | Command entries minus one |
| rx_pop | input | 1 | Remove the head byte of the receive queue |
| rx_data | output | 8 | Head byte of the receive queue |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_level | output | 5 | Bytes in the receive queue |
| eng_req | output | 1 | Operation request to the bit engine, held until eng_done |
| eng_op | output | 2 | Operation code |
| eng_wdata | output | 8 | Byte to write |
| eng_nack_out | output | 1 | Acknowledge bit to send after a read (1 = NACK) |
| eng_done | input | 1 | One-cycle completion from the engine |
| eng_nack | input | 1 | Written byte was refused, valid with eng_done |
| eng_rdata | input | 8 | Read byte, valid with eng_done |
| bus_busy | output | 1 | This master holds the bus |
| ev_tx_error | output | 1 | Pulse: written byte refused |
| ev_bus_idle | output | 1 | Pulse: stop completed |
| ev_tx_empty | output | 1 | Pulse: command queue drained |
| ev_tx_half | output | 1 | Pulse: command queue fell to half |

## Verification
A wrong internal state shows up at the engine port on the next request. A stale read count or direction bit turns an expected write into a read, and a wrong remaining count moves the NACK off the final read. Both are visible in the operation sequence within a few engine round trips. An ownership flag left set shows as bus_busy remaining 1 after the stop and as a missing ev_bus_idle. A wrong queue count shows immediately in tx_level, and it shifts or drops the empty and half events during the next drain.

// File: rtl/i2c_seq_pkg.sv
// Shared constants for the I2C command sequencer: entry fields, engine
// operation codes and the sequencer state type.
package i2c_seq_pkg;
    localparam int ENTRY_W   = 10;
    localparam int START_BIT = 8;
    localparam int STOP_BIT  = 9;

    localparam logic [1:0] OP_START = 2'd0;
    localparam logic [1:0] OP_STOP  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;
    localparam logic [1:0] OP_READ  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WRITE,
        ST_READ,
        ST_STOP
    } seq_state_e;
endpackage

// File: rtl/i2c_seq_fifo.sv
// Synchronous FIFO with a flush input and a combinational head.
// Assumes DEPTH is a power of two. A push while full is dropped, and a pop
// while empty is ignored.
module i2c_seq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Store the pushed word.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Move the pointers and the count, with flush taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/i2c_seq_fsm.sv
// Byte-level sequencer. It pops one command entry at a time, turns it into
// engine operations and tracks bus ownership. It assumes the engine holds
// eng_done for one cycle per accepted request.
module i2c_seq_fsm
    import i2c_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               tx_flush,
    input  logic [ENTRY_W-1:0] head,
    input  logic               head_valid,
    output logic               pop,
    output logic               seq_flush,
    output logic               eng_req,
    output logic [1:0]         eng_op,
    output logic [7:0]         eng_wdata,
    output logic               eng_nack_out,
    input  logic               eng_done,
    input  logic               eng_nack,
    output logic               rx_push,
    output logic               bus_busy,
    output logic               ev_tx_error,
    output logic               ev_bus_idle
);
    seq_state_e state;
    logic [7:0] ent_data;
    logic       ent_stop;
    logic       ent_addr;
    logic       rd_pending;
    logic [7:0] rd_left;
    logic       owned;

    assign bus_busy = owned;

    // Engine request and queue controls follow from the state.
    always_comb begin
        pop          = (state == ST_IDLE) && enable && head_valid;
        eng_req      = (state != ST_IDLE);
        eng_wdata    = ent_data;
        eng_nack_out = (state == ST_READ) && (rd_left == 8'd1);
        rx_push      = (state == ST_READ) && eng_done;
        seq_flush    = (state == ST_WRITE) && eng_done && eng_nack;
        case (state)
            ST_START: eng_op = OP_START;
            ST_READ:  eng_op = OP_READ;
            ST_STOP:  eng_op = OP_STOP;
            default:  eng_op = OP_WRITE;
        endcase
    end

    // State, latched entry, read count and ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ent_data    <= '0;
            ent_stop    <= 1'b0;
            ent_addr    <= 1'b0;
            rd_pending  <= 1'b0;
            rd_left     <= '0;
            owned       <= 1'b0;
            ev_tx_error <= 1'b0;
            ev_bus_idle <= 1'b0;
        end else begin
            ev_tx_error <= 1'b0;
            ev_bus_idle <= 1'b0;
            if (tx_flush) rd_pending <= 1'b0;
            case (state)
                ST_IDLE: if (pop) begin
                    ent_data <= head[7:0];
                    ent_stop <= head[STOP_BIT];
                    ent_addr <= head[START_BIT];
                    if (head[START_BIT]) begin
                        owned      <= 1'b1;
                        rd_pending <= 1'b0;
                        state      <= ST_START;
                    end else if (rd_pending) begin
                        rd_left    <= head[7:0];
                        rd_pending <= 1'b0;
                        state      <= ST_READ;
                    end else begin
                        state <= ST_WRITE;
                    end
                end
                ST_START: if (eng_done) state <= ST_WRITE;
                ST_WRITE: if (eng_done) begin
                    if (eng_nack) begin
                        ev_tx_error <= 1'b1;
                        rd_pending  <= 1'b0;
                        state       <= ST_STOP;
                    end else if (ent_stop) begin
                        state <= ST_STOP;
                    end else begin
                        if (ent_addr && ent_data[0]) rd_pending <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_READ: if (eng_done) begin
                    rd_left <= rd_left - 1'b1;
                    if (rd_left == 8'd1) state <= ent_stop ? ST_STOP : ST_IDLE;
                end
                ST_STOP: if (eng_done) begin
                    owned       <= 1'b0;
                    ev_bus_idle <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cmd_sequencer.sv
// Top of the I2C command sequencer: command queue, receive queue, sequencer
// and queue-level events. Assumes TX_DEPTH and RX_DEPTH are powers of two.
module i2c_cmd_sequencer
    import i2c_seq_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16,
    localparam int TCW     = $clog2(TX_DEPTH + 1),
    localparam int TLW     = $clog2(TX_DEPTH),
    localparam int RCW     = $clog2(RX_DEPTH + 1),
    localparam int HALF    = TX_DEPTH / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               tx_flush,
    input  logic               cmd_push,
    input  logic [ENTRY_W-1:0] cmd_data,
    output logic               cmd_full,
    output logic               tx_empty,
    output logic [TLW-1:0]     tx_level,
    input  logic               rx_pop,
    output logic [7:0]         rx_data,
    output logic               rx_valid,
    output logic [RCW-1:0]     rx_level,
    output logic               eng_req,
    output logic [1:0]         eng_op,
    output logic [7:0]         eng_wdata,
    output logic               eng_nack_out,
    input  logic               eng_done,
    input  logic               eng_nack,
    input  logic [7:0]         eng_rdata,
    output logic               bus_busy,
    output logic               ev_tx_error,
    output logic               ev_bus_idle,
    output logic               ev_tx_empty,
    output logic               ev_tx_half
);
    logic [ENTRY_W-1:0] head;
    logic [TCW-1:0]     tx_count;
    logic               pop, seq_flush, rx_push, rx_empty, rx_full;
    logic               solo_pop;

    i2c_seq_fifo #(.W(ENTRY_W), .DEPTH(TX_DEPTH)) u_cmd_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush || seq_flush),
        .push(cmd_push), .din(cmd_data), .pop(pop),
        .head(head), .count(tx_count), .empty(tx_empty), .full(cmd_full)
    );

    i2c_seq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push(rx_push), .din(eng_rdata), .pop(rx_pop),
        .head(rx_data), .count(rx_level), .empty(rx_empty), .full(rx_full)
    );

    i2c_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_flush(tx_flush),
        .head(head), .head_valid(!tx_empty), .pop(pop), .seq_flush(seq_flush),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_nack_out(eng_nack_out), .eng_done(eng_done), .eng_nack(eng_nack),
        .rx_push(rx_push), .bus_busy(bus_busy),
        .ev_tx_error(ev_tx_error), .ev_bus_idle(ev_bus_idle)
    );

    assign rx_valid = !rx_empty;
    assign tx_level = tx_empty ? '0 : TLW'(tx_count - 1'b1);
    // A pop with no push in the same cycle and no flush moves the count down by one.
    assign solo_pop = pop && !(cmd_push && !cmd_full) && !tx_flush && !seq_flush;

    // Level events, aligned with the count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_tx_empty <= 1'b0;
            ev_tx_half  <= 1'b0;
        end else begin
            ev_tx_empty <= solo_pop && (tx_count == TCW'(1));
            ev_tx_half  <= solo_pop && (tx_count == TCW'(HALF + 1));
        end
    end

    logic unused_rx_full;
    assign unused_rx_full = rx_full;
endmodule

// File: rtl/i2c_seq_checker.sv
// Protocol checker for the I2C command sequencer, attached with bind.
module i2c_seq_checker #(
    parameter int TX_DEPTH = 16,
    localparam int TLW     = $clog2(TX_DEPTH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           eng_req,
    input logic [1:0]     eng_op,
    input logic [7:0]     eng_wdata,
    input logic           eng_done,
    input logic           bus_busy,
    input logic           cmd_full,
    input logic           tx_empty,
    input logic [TLW-1:0] tx_level,
    input logic           ev_tx_error,
    input logic           ev_bus_idle,
    input logic           ev_tx_empty,
    input logic           ev_tx_half
);
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata)));

    assert_error_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_error |-> (eng_req && eng_op == 2'd1));

    assert_full_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_full |-> (tx_level == TLW'(TX_DEPTH - 1)));

    assert_empty_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_empty |-> tx_empty);

    assert_half_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_half |-> (!tx_empty && tx_level == TLW'(TX_DEPTH / 2 - 1)));

    assert_start_owned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == 2'd0) |-> bus_busy);

    assert_idle_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_idle |-> !bus_busy);
endmodule

bind i2c_cmd_sequencer i2c_seq_checker #(.TX_DEPTH(TX_DEPTH)) u_seq_checker (
    .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_op(eng_op),
    .eng_wdata(eng_wdata), .eng_done(eng_done), .bus_busy(bus_busy),
    .cmd_full(cmd_full), .tx_empty(tx_empty), .tx_level(tx_level),
    .ev_tx_error(ev_tx_error), .ev_bus_idle(ev_bus_idle),
    .ev_tx_empty(ev_tx_empty), .ev_tx_half(ev_tx_half)
);

// File: tb/test_i2c_cmd_sequencer.sv
module test_i2c_cmd_sequencer;
    localparam int OPS = 0, OPP = 1, OPW = 2, OPR = 3;
    localparam logic [9:0] F_START = 10'h100, F_STOP = 10'h200;

    logic clk = 0, rst_n = 0, enable = 0, tx_flush = 0, cmd_push = 0, rx_pop = 0;
    logic [9:0] cmd_data = '0;
    logic cmd_full, tx_empty, rx_valid, eng_req, eng_nack_out, bus_busy;
    logic [3:0] tx_level;
    logic [4:0] rx_level;
    logic [7:0] rx_data, eng_wdata, eng_rdata;
    logic [1:0] eng_op;
    logic eng_done, eng_nack;
    logic ev_tx_error, ev_bus_idle, ev_tx_empty, ev_tx_half;

    always #10 clk = ~clk;

    i2c_cmd_sequencer i_i2c_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_flush(tx_flush),
        .cmd_push(cmd_push), .cmd_data(cmd_data), .cmd_full(cmd_full),
        .tx_empty(tx_empty), .tx_level(tx_level), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_level(rx_level),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_nack_out(eng_nack_out), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_rdata(eng_rdata), .bus_busy(bus_busy), .ev_tx_error(ev_tx_error),
        .ev_bus_idle(ev_bus_idle), .ev_tx_empty(ev_tx_empty), .ev_tx_half(ev_tx_half)
    );

    // Bit-engine model with an operation log.
    int   log_n = 0, rd_ctr = 0, tmr = 0;
    bit   eng_busy = 0, nack_writes = 0;
    int   op_log [256];
    int   dat_log[256];
    bit   ack_log[256];
    bit   bsy_log[256];
    int   n_err = 0, n_idle = 0, n_empty = 0, n_half = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            eng_busy <= 0; eng_done <= 0; eng_nack <= 0; eng_rdata <= 0;
        end else if (eng_done) begin
            eng_done <= 0; eng_busy <= 0; eng_nack <= 0;
        end else if (eng_busy) begin
            if (tmr == 0) begin
                eng_done  <= 1;
                eng_nack  <= nack_writes && (eng_op == 2'd2);
                eng_rdata <= 8'hC0 + 8'(rd_ctr);
                if (eng_op == 2'd3) rd_ctr <= rd_ctr + 1;
            end else tmr <= tmr - 1;
        end else if (eng_req) begin
            eng_busy <= 1; tmr <= 2;
            op_log[log_n & 255]  <= int'(eng_op);
            dat_log[log_n & 255] <= int'(eng_wdata);
            ack_log[log_n & 255] <= eng_nack_out;
            bsy_log[log_n & 255] <= bus_busy;
            log_n <= log_n + 1;
        end
    end

    always @(posedge clk) begin
        if (ev_tx_error) n_err  <= n_err + 1;
        if (ev_bus_idle) n_idle <= n_idle + 1;
        if (ev_tx_empty) n_empty <= n_empty + 1;
        if (ev_tx_half)  n_half <= n_half + 1;
    end

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [9:0] d);
        cmd_push = 1; cmd_data = d;
        @(negedge clk);
        cmd_push = 0;
    endtask

    task automatic run(input int cyc);
        enable = 1;
        repeat (cyc) @(negedge clk);
        enable = 0;
    endtask

    task automatic expect_op(input string req, input int idx, input int op, input int dat);
        check(op_log[idx & 255] == op, req, "op", op_log[idx & 255], op);
        if (op == OPW)
            check(dat_log[idx & 255] == dat, req, "write byte", dat_log[idx & 255], dat);
    endtask

    task automatic t_reset();
        check(eng_req == 0 && bus_busy == 0 && rx_valid == 0, "R1", "req/busy/rxv",
              {eng_req, bus_busy, rx_valid}, 0);
        check(tx_empty == 1 && tx_level == 0, "R1", "empty/level", {tx_empty, tx_level}, 5'h10);
        check({ev_tx_error, ev_bus_idle, ev_tx_empty, ev_tx_half} == 0, "R1", "events",
              {ev_tx_error, ev_bus_idle, ev_tx_empty, ev_tx_half}, 0);
    endtask

    task automatic t_write();
        int b = log_n, bi = n_idle;
        push(F_START | 10'h0A4); push(10'h033); push(F_STOP | 10'h05C);
        run(200);
        check(log_n - b == 5, "R2", "op count", log_n - b, 5);
        expect_op("R2", b, OPS, 0); expect_op("R2", b + 1, OPW, 'hA4);
        expect_op("R2", b + 2, OPW, 'h33); expect_op("R2", b + 3, OPW, 'h5C);
        expect_op("R2", b + 4, OPP, 0);
        check(bsy_log[(b + 3) & 255] == 1, "R11", "busy during write", bsy_log[(b + 3) & 255], 1);
        check(bus_busy == 0 && n_idle - bi == 1, "R11", "released", {bus_busy, 4'(n_idle - bi)}, 1);
    endtask

    task automatic t_read();
        int b = log_n;
        rd_ctr = 0;
        push(F_START | 10'h051); push(F_STOP | 10'h003);
        run(200);
        check(log_n - b == 6, "R3", "op count", log_n - b, 6);
        expect_op("R3", b, OPS, 0); expect_op("R3", b + 1, OPW, 'h51);
        for (int i = 0; i < 3; i++) begin
            expect_op("R3", b + 2 + i, OPR, 0);
            check(ack_log[(b + 2 + i) & 255] == (i == 2), "R3", "ack choice",
                  ack_log[(b + 2 + i) & 255], i == 2);
        end
        expect_op("R3", b + 5, OPP, 0);
        check(rx_level == 3, "R3", "rx level", rx_level, 3);
        for (int i = 0; i < 3; i++) begin
            check(rx_valid && rx_data == 8'hC0 + 8'(i), "R3", "rx byte", rx_data, 'hC0 + i);
            rx_pop = 1; @(negedge clk); rx_pop = 0;
        end
        check(rx_valid == 0, "R3", "rx drained", rx_valid, 0);
    endtask

    task automatic t_addr_only();
        int b = log_n, bi = n_idle;
        push(F_START | F_STOP | 10'h040);
        run(100);
        check(log_n - b == 3, "R4", "op count", log_n - b, 3);
        expect_op("R4", b, OPS, 0); expect_op("R4", b + 1, OPW, 'h40);
        expect_op("R4", b + 2, OPP, 0);
        check(n_idle - bi == 1 && bus_busy == 0, "R4", "bus released", n_idle - bi, 1);
    endtask

    task automatic t_restart();
        int b = log_n, bi = n_idle;
        push(F_START | 10'h020); push(10'h011);
        push(F_START | 10'h021); push(F_STOP | 10'h002);
        run(300);
        check(log_n - b == 8, "R5", "op count", log_n - b, 8);
        expect_op("R5", b + 2, OPW, 'h11); expect_op("R5", b + 3, OPS, 0);
        expect_op("R5", b + 4, OPW, 'h21); expect_op("R5", b + 7, OPP, 0);
        check(bsy_log[(b + 4) & 255] == 1 && n_idle - bi == 1, "R5", "bus kept",
              n_idle - bi, 1);
    endtask

    task automatic t_nack();
        int b = log_n, be = n_err;
        push(F_START | 10'h0B0); push(10'h001); push(F_STOP | 10'h002);
        nack_writes = 1;
        run(150);
        nack_writes = 0;
        check(log_n - b == 3, "R6", "op count", log_n - b, 3);
        expect_op("R6", b + 1, OPW, 'hB0); expect_op("R6", b + 2, OPP, 0);
        check(n_err - be == 1, "R6", "error event", n_err - be, 1);
        check(tx_empty == 1, "R6", "queue discarded", tx_empty, 1);
    endtask

    task automatic t_levels();
        int b = log_n, bh = n_half, be = n_empty;
        push(F_START | 10'h030);
        for (int i = 0; i < 14; i++) push(10'(i));
        push(F_STOP | 10'h0EE);
        check(cmd_full == 1 && tx_level == 15, "R7", "full level", tx_level, 15);
        push(10'h077);
        check(tx_level == 15, "R7", "push while full ignored", tx_level, 15);
        repeat (20) @(negedge clk);
        check(log_n == b && eng_req == 0 && tx_level == 15, "R9", "disabled idle", log_n - b, 0);
        run(400);
        check(log_n - b == 18, "R7", "ops after drain", log_n - b, 18);
        expect_op("R7", b + 16, OPW, 'hEE);
        check(n_half - bh == 1, "R8", "half events", n_half - bh, 1);
        check(n_empty - be == 1, "R8", "empty events", n_empty - be, 1);
    endtask

    task automatic t_flush();
        int b = log_n;
        push(F_START | 10'h061); push(10'h005); push(10'h006);
        check(tx_level == 2, "R7", "level three", tx_level, 2);
        tx_flush = 1; @(negedge clk); tx_flush = 0;
        check(tx_empty == 1 && tx_level == 0, "R10", "flushed", tx_level, 0);
        run(50);
        check(log_n == b, "R10", "no ops after flush", log_n - b, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_addr_only();
        t_restart();
        t_nack();
        t_levels();
        t_flush();
        finish_run();
    end
endmodule